// File: doc/BRIEF.md
# Software Flow Control Receive Detector

This block sits behind a UART receiver and inspects every received character for in-band flow control. When the far end sends its "stop" pattern, the block raises a suspend state. It then tells the local transmitter to hold off once the character currently on the line has finished. When the "go" pattern arrives, transmission resumes. Patterns can be one character long, or a pair of characters that must arrive back to back. Every comparison is limited to the active word length.

Characters used for flow control never reach the receive FIFO. In pair mode, a character that could start a pair is withheld for one character time. If the pair does not complete, that character is handed back on a second write lane, `hold_wr` with `hold_data`, and the new character is judged again as a possible pair start. An optional special-character mode sets the stop flag when a stored character equals the second stop pattern, and that character is still written to the FIFO.

The pattern values are inputs from registers held elsewhere, so reset does not disturb them. The build parameter `DOUBLE_EN` removes the pair logic when only single-character patterns are needed.

Top module: `swfc_rx_detect`

## Requirements
- R1: In single mode (`dbl_mode`=0, `fc_en`=1), a valid character equal to `xoff1` sets `suspended` and `xoff_flag` at the next clock edge. A valid character equal to `xon1` clears both at the next edge.
- R2: In pair mode (`dbl_mode`=1), the stop action needs `xoff1` followed by `xoff2` on two consecutive valid characters, and the go action needs `xon1` followed by `xon2`. Idle cycles between the two characters are allowed.
- R3: In pair mode, a valid character matching `xon1` or `xoff1` is withheld. If the next valid character does not complete the pair, the withheld character appears on `hold_wr`/`hold_data` in that same cycle. The new character is then treated as a possible first character of a new pair.
- R4: `fifo_wr` equals `rx_valid`, except that it stays low for any character that completes a match, is withheld, or matches in single mode.
- R5: `wlen_sel` selects the compared width: 0 compares 5 bits, 1 compares 6, 2 compares 7 and 3 compares 8, always the low-order bits. Higher bits of both data and patterns are ignored.
- R6: `tx_stop` rises at the first clock edge after `suspended` is set at which `tx_busy` is low, and it stays low while `tx_busy` is high. It falls at the clock edge after `suspended` clears.
- R7: `irq` is high exactly when `xoff_flag` and `xoff_irq_en` are both high.
- R8: With `spc_en`=1, a valid character that is written through `fifo_wr` and equals `xoff2` sets `xoff_flag` at the next edge.
- R9: With `fc_en`=0, no character is matched or withheld, `suspended` clears at the next edge, and a withheld character is released on `hold_wr` in that cycle.
- R10: If both a go match and a stop match complete on the same character, the go match wins while suspended and the stop match wins otherwise.
- R11: Reset clears `suspended`, `xoff_flag`, `tx_stop` and any withheld character.
- R12: Dropping `dbl_mode` while a character is withheld releases it on `hold_wr` in that cycle and discards the partial pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| wlen_sel | input | 2 | Word length select (0..3 gives CHAR_W-3..CHAR_W bits) |
| fc_en | input | 1 | Flow control enable |
| dbl_mode | input | 1 | Pair matching mode |
| spc_en | input | 1 | Special-character detection enable |
| xoff_irq_en | input | 1 | Interrupt enable for the stop flag |
| xon1 | input | CHAR_W | First go pattern |
| xon2 | input | CHAR_W | Second go pattern |
| xoff1 | input | CHAR_W | First stop pattern |
| xoff2 | input | CHAR_W | Second stop pattern / special character |
| tx_busy | input | 1 | Transmitter is mid-character |
| fifo_wr | output | 1 | Store current character into RX FIFO |
| hold_wr | output | 1 | Store the released withheld character |
| hold_data | output | CHAR_W | Withheld character value |
| suspended | output | 1 | Flow suspended state |
| xoff_flag | output | 1 | Stop / special-character status flag |
| irq | output | 1 | Interrupt request |
| tx_stop | output | 1 | Transmit halt, applied at character boundaries |

## Verification
The two functions that collide are the release of a withheld character and the write of the new character. A broken pair produces `hold_wr` and `fifo_wr` in the same cycle, with different data on each lane. The bench provokes this by sending `xoff1` or `xon1` in pair mode and following it with an ordinary character. It also follows `xoff1` with `xon1`, so the release coincides with a fresh withholding instead of a write. A behavioural model tracks the withheld character in a queue and compares both lanes, the state outputs and `tx_stop` on every clock, so a missing, doubled or misordered write is caught in the cycle it happens.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
   // word-length select: compared width is CHAR_W-3 .. CHAR_W
   typedef enum logic [1:0] {
      WLEN_M3   = 2'd0,
      WLEN_M2   = 2'd1,
      WLEN_M1   = 2'd2,
      WLEN_FULL = 2'd3
   } wlen_e;

   // completed flow-control match events for one character
   typedef struct packed {
      logic on;
      logic off;
   } fc_ev_t;

   localparam int PAT_XON1  = 0;
   localparam int PAT_XON2  = 1;
   localparam int PAT_XOFF1 = 2;
   localparam int PAT_XOFF2 = 3;
   localparam int PAT_NUM   = 4;
endpackage

// File: rtl/swfc_cmp.sv
module swfc_cmp
   import swfc_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic [1:0]        wlen_sel,
   input  logic [CHAR_W-1:0] a,
   input  logic [CHAR_W-1:0] b,
   output logic              hit
);
   localparam int SPAN_MIN = CHAR_W - 3;

   int                act_w;
   logic [CHAR_W-1:0] mask;

   always_comb begin
      case (wlen_e'(wlen_sel))
         WLEN_M3:   act_w = SPAN_MIN;
         WLEN_M2:   act_w = SPAN_MIN + 1;
         WLEN_M1:   act_w = SPAN_MIN + 2;
         WLEN_FULL: act_w = CHAR_W;
      endcase
      for (int i = 0; i < CHAR_W; i++) begin
         mask[i] = (i < act_w);
      end
   end

   assign hit = (((a ^ b) & mask) == '0);
endmodule

// File: rtl/swfc_seq.sv
module swfc_seq
   import swfc_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter bit DOUBLE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [CHAR_W-1:0]  rx_data,
   input  logic               fc_en,
   input  logic               dbl_mode,
   input  logic [PAT_NUM-1:0] hit,
   output fc_ev_t             ev,
   output logic               take,
   output logic               hold_wr,
   output logic [CHAR_W-1:0]  hold_data
);
   generate
      if (DOUBLE_EN) begin : g_dbl
         logic              pend_on;
         logic              pend_off;
         logic [CHAR_W-1:0] held;
         logic              pend_any;
         logic              dbl_live;
         logic              done;
         logic              first_hit;

         always_comb begin
            pend_any  = pend_on | pend_off;
            dbl_live  = fc_en & dbl_mode;
            ev.on     = rx_valid & fc_en &
                        (dbl_live ? (pend_on & hit[PAT_XON2]) : hit[PAT_XON1]);
            ev.off    = rx_valid & fc_en &
                        (dbl_live ? (pend_off & hit[PAT_XOFF2]) : hit[PAT_XOFF1]);
            done      = ev.on | ev.off;
            first_hit = rx_valid & dbl_live & ~done &
                        (hit[PAT_XON1] | hit[PAT_XOFF1]);
            take      = done | first_hit;
            hold_wr   = pend_any & (~dbl_live | (rx_valid & ~done));
            hold_data = held;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_on  <= 1'b0;
               pend_off <= 1'b0;
               held     <= '0;
            end else if (!dbl_live) begin
               pend_on  <= 1'b0;
               pend_off <= 1'b0;
            end else if (rx_valid) begin
               if (done) begin
                  pend_on  <= 1'b0;
                  pend_off <= 1'b0;
               end else begin
                  pend_on  <= hit[PAT_XON1];
                  pend_off <= hit[PAT_XOFF1];
                  held     <= rx_data;
               end
            end
         end

         // R3 / R12: a release without a new character empties the slot
         p_hold_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_wr && !rx_valid) |=> !hold_wr);
         // R12: leaving pair mode leaves nothing withheld afterwards
         p_drop_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!dbl_mode && !rx_valid) |=> !hold_wr);
      end else begin : g_sgl
         always_comb begin
            ev.on     = rx_valid & fc_en & hit[PAT_XON1];
            ev.off    = rx_valid & fc_en & hit[PAT_XOFF1];
            take      = ev.on | ev.off;
            hold_wr   = 1'b0;
            hold_data = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/swfc_gate.sv
module swfc_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic suspended,
   input  logic tx_busy,
   output logic tx_stop
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_stop <= 1'b0;
      else        tx_stop <= suspended & (tx_stop | ~tx_busy);
   end

   // R6: the halt only begins on a character boundary
   p_stop_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_stop) |-> !$past(tx_busy));
   // R6: the halt follows the suspend state down one edge later
   p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !suspended |=> !tx_stop);
endmodule

// File: rtl/swfc_rx_detect.sv
module swfc_rx_detect
   import swfc_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter bit DOUBLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic [1:0]        wlen_sel,
   input  logic              fc_en,
   input  logic              dbl_mode,
   input  logic              spc_en,
   input  logic              xoff_irq_en,
   input  logic [CHAR_W-1:0] xon1,
   input  logic [CHAR_W-1:0] xon2,
   input  logic [CHAR_W-1:0] xoff1,
   input  logic [CHAR_W-1:0] xoff2,
   input  logic              tx_busy,
   output logic              fifo_wr,
   output logic              hold_wr,
   output logic [CHAR_W-1:0] hold_data,
   output logic              suspended,
   output logic              xoff_flag,
   output logic              irq,
   output logic              tx_stop
);
   generate
      if (CHAR_W < 4 || CHAR_W > 16) begin : g_bad_width
         $error("swfc_rx_detect: CHAR_W must lie in 4..16");
      end
   endgenerate

   logic [CHAR_W-1:0]  pat [PAT_NUM];
   logic [PAT_NUM-1:0] hit;
   fc_ev_t             ev;
   logic               take;
   logic               resume;
   logic               halt;
   logic               spec_hit;
   logic               susp_q;
   logic               flag_q;

   assign pat[PAT_XON1]  = xon1;
   assign pat[PAT_XON2]  = xon2;
   assign pat[PAT_XOFF1] = xoff1;
   assign pat[PAT_XOFF2] = xoff2;

   generate
      for (genvar k = 0; k < PAT_NUM; k++) begin : g_cmp
         swfc_cmp #(.CHAR_W(CHAR_W)) u_cmp (
            .wlen_sel (wlen_sel),
            .a        (rx_data),
            .b        (pat[k]),
            .hit      (hit[k])
         );
      end
   endgenerate

   swfc_seq #(.CHAR_W(CHAR_W), .DOUBLE_EN(DOUBLE_EN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .fc_en     (fc_en),
      .dbl_mode  (dbl_mode),
      .hit       (hit),
      .ev        (ev),
      .take      (take),
      .hold_wr   (hold_wr),
      .hold_data (hold_data)
   );

   // go beats stop while suspended, stop beats go otherwise
   assign resume   = ev.on  & (susp_q | ~ev.off);
   assign halt     = ev.off & ~(susp_q & ev.on);
   assign fifo_wr  = rx_valid & ~take;
   assign spec_hit = spc_en & fifo_wr & hit[PAT_XOFF2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (!fc_en)      susp_q <= 1'b0;
         else if (halt)   susp_q <= 1'b1;
         else if (resume) susp_q <= 1'b0;

         if (halt || spec_hit) flag_q <= 1'b1;
         else if (resume)      flag_q <= 1'b0;
      end
   end

   assign suspended = susp_q;
   assign xoff_flag = flag_q;
   assign irq       = flag_q & xoff_irq_en;

   swfc_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .suspended (susp_q),
      .tx_busy   (tx_busy),
      .tx_stop   (tx_stop)
   );

   // R1: entering suspend always raises the stop flag
   p_rise_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> xoff_flag);
   // R1: a resume with flow control on clears the flag
   p_resume_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(suspended) && $past(fc_en)) |-> !xoff_flag);
   // R9: disabling flow control releases the suspend state
   p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fc_en |=> !suspended);
   // R4: a single-mode go character is never stored
   p_flow_not_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && fc_en && !dbl_mode && hit[PAT_XON1]) |-> !fifo_wr);
   // R8: a stored special character raises the flag
   p_special_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_en && rx_valid && !fc_en && hit[PAT_XOFF2]) |=> xoff_flag);
endmodule

// File: tb/swfc_rx_detect_tb.sv
module swfc_rx_detect_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         rx_valid;
   logic [W-1:0] rx_data;
   logic [1:0]   wlen_sel;
   logic         fc_en, dbl_mode, spc_en, xoff_irq_en, tx_busy;
   logic [W-1:0] xon1, xon2, xoff1, xoff2;
   logic         fifo_wr, hold_wr, suspended, xoff_flag, irq, tx_stop;
   logic [W-1:0] hold_data;

   always #2 clk = ~clk;   // 250 MHz

   swfc_rx_detect #(.CHAR_W(W), .DOUBLE_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .wlen_sel(wlen_sel), .fc_en(fc_en), .dbl_mode(dbl_mode), .spc_en(spc_en),
      .xoff_irq_en(xoff_irq_en), .xon1(xon1), .xon2(xon2), .xoff1(xoff1),
      .xoff2(xoff2), .tx_busy(tx_busy), .fifo_wr(fifo_wr), .hold_wr(hold_wr),
      .hold_data(hold_data), .suspended(suspended), .xoff_flag(xoff_flag),
      .irq(irq), .tx_stop(tx_stop)
   );

   int    total = 0;
   int    bad   = 0;
   string cur_req = "R11";
   bit    finished = 0;

   // reference state
   bit         m_susp, m_flag, m_stop, p_on, p_off;
   logic [7:0] held_q[$];

   function automatic bit eqm(logic [7:0] a, logic [7:0] b, logic [1:0] wl);
      int         n = 5 + int'(wl);
      logic [7:0] m = 8'((1 << n) - 1);
      return ((a ^ b) & m) == 8'h00;
   endfunction

   task automatic chk(string tag, string sig, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s %s act=%0b exp=%0b t=%0t", cur_req, tag, sig, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit dl, con, coff, done, first, e_fifo, e_hold, r_res, r_halt, spec;
      bit n_susp, n_flag, n_stop;
      if (!rst_n) begin
         m_susp = 0; m_flag = 0; m_stop = 0; p_on = 0; p_off = 0;
         held_q.delete();
         chk("R11", "suspended", suspended, 1'b0);
         chk("R11", "xoff_flag", xoff_flag, 1'b0);
         chk("R11", "tx_stop", tx_stop, 1'b0);
         chk("R11", "hold_wr", hold_wr, 1'b0);
      end else begin
         dl   = fc_en && dbl_mode;
         con  = rx_valid && fc_en && (dl ? (p_on  && eqm(rx_data, xon2,  wlen_sel))
                                         :  eqm(rx_data, xon1,  wlen_sel));
         coff = rx_valid && fc_en && (dl ? (p_off && eqm(rx_data, xoff2, wlen_sel))
                                         :  eqm(rx_data, xoff1, wlen_sel));
         done  = con || coff;
         first = rx_valid && dl && !done &&
                 (eqm(rx_data, xon1, wlen_sel) || eqm(rx_data, xoff1, wlen_sel));
         e_fifo = rx_valid && !done && !first;
         e_hold = (held_q.size() > 0) && (!dl || (rx_valid && !done));

         chk("R4", "fifo_wr", fifo_wr, e_fifo);
         chk("R3", "hold_wr", hold_wr, e_hold);
         if (e_hold) begin
            total++;
            if (hold_data !== held_q[0]) begin
               bad++;
               $display("FAIL %s R3 hold_data act=%02h exp=%02h t=%0t", cur_req, hold_data, held_q[0], $time);
            end
         end
         chk("R1", "suspended", suspended, m_susp);
         chk("R1", "xoff_flag", xoff_flag, m_flag);
         chk("R7", "irq", irq, m_flag && xoff_irq_en);
         chk("R6", "tx_stop", tx_stop, m_stop);

         r_res  = con  && (m_susp || !coff);
         r_halt = coff && !(m_susp && con);
         spec   = spc_en && e_fifo && eqm(rx_data, xoff2, wlen_sel);
         n_susp = !fc_en ? 1'b0 : r_halt ? 1'b1 : r_res ? 1'b0 : m_susp;
         n_flag = (r_halt || spec) ? 1'b1 : r_res ? 1'b0 : m_flag;
         n_stop = m_susp && (m_stop || !tx_busy);
         if (!dl) begin
            p_on = 0; p_off = 0; held_q.delete();
         end else if (rx_valid) begin
            held_q.delete();
            if (done) begin
               p_on = 0; p_off = 0;
            end else begin
               p_on  = eqm(rx_data, xon1,  wlen_sel);
               p_off = eqm(rx_data, xoff1, wlen_sel);
               if (p_on || p_off) held_q.push_back(rx_data);
            end
         end
         m_susp = n_susp; m_flag = n_flag; m_stop = n_stop;
      end
   end

   task automatic cyc(bit v, logic [7:0] d);
      @(posedge clk); #1;
      rx_valid = v;
      rx_data  = d;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; rx_valid = 0; rx_data = 0; wlen_sel = 2'd3;
      fc_en = 0; dbl_mode = 0; spc_en = 0; xoff_irq_en = 0; tx_busy = 0;
      xon1 = 8'h11; xon2 = 8'h22; xoff1 = 8'h13; xoff2 = 8'h24;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;

      // R1 / R6 / R7: single mode, stop held off by a busy transmitter
      cur_req = "R1"; fc_en = 1; xoff_irq_en = 1;
      cyc(1, 8'h41); cyc(1, 8'h42);
      cur_req = "R6"; tx_busy = 1;
      cyc(1, 8'h13); idle(3);
      tx_busy = 0; idle(2);
      cyc(1, 8'h55);
      cur_req = "R7"; xoff_irq_en = 0; idle(1); xoff_irq_en = 1;
      cur_req = "R1"; cyc(1, 8'h11); idle(3);

      // R5: word-length masking
      cur_req = "R5"; wlen_sel = 2'd0;
      cyc(1, 8'hF3); idle(1);
      cyc(1, 8'h03); cyc(1, 8'hB1); idle(1);
      wlen_sel = 2'd2; cyc(1, 8'h93); cyc(1, 8'h91); wlen_sel = 2'd1;
      cyc(1, 8'h53); cyc(1, 8'h51); wlen_sel = 2'd3;
      cyc(1, 8'h93); idle(2);

      // R2: pair mode with gaps
      cur_req = "R2"; dbl_mode = 1;
      cyc(1, 8'h13); idle(2); cyc(1, 8'h24); idle(2);
      cyc(1, 8'h11); cyc(1, 8'h22); idle(2);

      // R3: broken pairs, release and write in one cycle
      cur_req = "R3";
      cyc(1, 8'h13); cyc(1, 8'h41);
      cyc(1, 8'h11); cyc(1, 8'h13); cyc(1, 8'h11); cyc(1, 8'h22);
      cyc(1, 8'h13); cyc(1, 8'h13); cyc(1, 8'h24); idle(2);
      cyc(1, 8'h11); cyc(1, 8'h22); idle(2);

      // R12: leaving pair mode with a withheld character
      cur_req = "R12";
      cyc(1, 8'h13); idle(1); dbl_mode = 0; idle(2);
      dbl_mode = 1; cyc(1, 8'h11); dbl_mode = 0; rx_data = 8'h13; idle(1);
      dbl_mode = 1; cyc(1, 8'h11); cyc(1, 8'h22); idle(2);

      // R9: disable while suspended and while withholding
      cur_req = "R9";
      cyc(1, 8'h13); cyc(1, 8'h24); idle(1);
      cyc(1, 8'h13); fc_en = 0; rx_valid = 0; idle(3);
      cyc(1, 8'h13); cyc(1, 8'h11); fc_en = 1; idle(2);

      // R8: special character stored and flagged
      cur_req = "R8"; dbl_mode = 0; spc_en = 1; fc_en = 0;
      cyc(1, 8'h24); idle(1);
      fc_en = 1; cyc(1, 8'h11); cyc(1, 8'hA4); wlen_sel = 2'd0;
      cyc(1, 8'h04); cyc(1, 8'h64); wlen_sel = 2'd3; cyc(1, 8'h11);
      spc_en = 0; cyc(1, 8'h24); idle(2);

      // R10: identical go and stop patterns
      cur_req = "R10"; xon1 = 8'h55; xoff1 = 8'h55;
      cyc(1, 8'h55); idle(1); cyc(1, 8'h55); idle(1); cyc(1, 8'h55); idle(1);
      dbl_mode = 1; xon2 = 8'h66; xoff2 = 8'h66;
      cyc(1, 8'h55); cyc(1, 8'h66); idle(1);
      cyc(1, 8'h55); cyc(1, 8'h66); idle(1);
      xon1 = 8'h11; xon2 = 8'h22; xoff1 = 8'h13; xoff2 = 8'h24;

      // R11: reset in the middle of a suspend with a withheld character
      cur_req = "R11";
      cyc(1, 8'h13); cyc(1, 8'h24); cyc(1, 8'h11);
      @(posedge clk); #1 rst_n = 0; rx_valid = 0;
      idle(2); rst_n = 1; idle(2);

      // mixed stream across all modes
      cur_req = "R4";
      for (int i = 0; i < 4000; i++) begin
         int        sel = $urandom_range(0, 7);
         logic [7:0] d;
         case (sel)
            0: d = xon1;  1: d = xon2;  2: d = xoff1;  3: d = xoff2;
            default: d = 8'($urandom);
         endcase
         if (($urandom_range(0, 3)) == 0) d = d ^ 8'hE0;
         cyc($urandom_range(0, 3) != 0, d);
         if ($urandom_range(0, 40) == 0) fc_en    = ~fc_en;
         if ($urandom_range(0, 30) == 0) dbl_mode = ~dbl_mode;
         if ($urandom_range(0, 30) == 0) spc_en   = ~spc_en;
         if ($urandom_range(0, 50) == 0) wlen_sel = 2'($urandom);
         if ($urandom_range(0, 5)  == 0) tx_busy  = ~tx_busy;
         if ($urandom_range(0, 20) == 0) xoff_irq_en = ~xoff_irq_en;
      end
      idle(4);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule